// File: doc/BRIEF.md
# Modem Status Keeper for an Eight-Line Terminal Multiplexer

This block holds the read-only modem status word of a terminal multiplexer. Each line has two bits: a ring flag and a carrier flag. Three kinds of input move these bits:

- connection events on a line;
- the terminal-ready bits that software writes into the transmit control word;
- lines that go down or are disconnected.

A new call shows as ringing until software raises terminal-ready for that line. At that point the call turns into carrier.

An optional hang-up mode watches the terminal-ready bits. When software drops terminal-ready on a connected line, the block emits a one-cycle hang-up pulse for that line and clears its carrier.

The surrounding controller supplies the following:

- per-line connect and disconnect pulses;
- per-line connected levels;
- a strobe and data word for each transmit control write;
- two static enables, one for modem control and one for hang-up.

The block does no physical modem signalling.

Top module: `mdm_status_keeper`

## Requirements
- R1: The status word `msr_o` carries the ring flags in bits NUM_LINES-1:0 and the carrier flags in bits 2*NUM_LINES-1:NUM_LINES, one bit per line. After reset the status word is zero and `hangup_o` is zero.
- R2: With modem control enabled, a connect pulse sets the line's carrier if its terminal-ready bit is 1, and otherwise sets its ring flag. The terminal-ready value used is the one being written in that cycle if a write occurs, else the held value.
- R3: With modem control enabled, a transmit control write sets the carrier of every line that is ringing and whose new terminal-ready bit is 1.
- R4: With modem control enabled, the same write clears the ring flag of every line whose new terminal-ready bit is 1.
- R5: With both enables set, a write that takes a connected line's terminal-ready bit from 1 to 0 raises that line's bit of `hangup_o` for exactly the following cycle and clears that line's carrier.
- R6: With modem control enabled, a line whose `line_up_i` bit is 0 has carrier 0 in the next cycle. This overrides any set in the same cycle.
- R7: With modem control enabled, a disconnect pulse clears both the ring flag and the carrier of that line.
- R8: With modem control disabled, writes, connect and disconnect pulses and line levels leave `msr_o` unchanged, and `hangup_o` stays 0. Terminal-ready is still recorded from writes.
- R9: The hang-up enable alone, without modem control, never produces a hang-up pulse.
- R10: A `full_init_i` pulse clears the status word, the held terminal-ready bits and `hangup_o` in the next cycle, taking priority over every other input.
- R11: Terminal-ready is taken from bits 2*NUM_LINES-1:NUM_LINES of `tcr_data_i`. The low bits are ignored.
- R12: All outputs are registered: an input change shows at the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_init_i | input | 1 | Synchronous full initialisation |
| mdm_en_i | input | 1 | Static modem control enable |
| auto_hup_en_i | input | 1 | Static hang-up-on-drop enable |
| conn_i | input | NUM_LINES | Per-line new connection pulse |
| disc_i | input | NUM_LINES | Per-line disconnect pulse |
| line_up_i | input | NUM_LINES | Per-line connected level |
| tcr_wr_i | input | 1 | Transmit control write strobe |
| tcr_data_i | input | 2*NUM_LINES | Transmit control write data (terminal-ready in upper half) |
| msr_o | output | 2*NUM_LINES | Status word: carrier upper half, ring lower half |
| hangup_o | output | NUM_LINES | Per-line hang-up pulse |

## Verification
A wrong held terminal-ready bit stays invisible until a later event reads it. That event is a connect that picks ring instead of carrier, or a write that fails to raise a hang-up. The bench therefore always follows a preload with such an event and checks the status word one cycle later. A stuck ring or carrier flag, or a missed line-down clear, shows in `msr_o` on the cycle after the causing input. Sweeps over every terminal-ready pattern, each paired with a line-up pattern, catch faults on single lines and faults in masks.

// File: rtl/mdm_status_pkg.sv
package mdm_status_pkg;
   localparam int MAX_LINES = 16;

   typedef struct packed {
      logic carrier;
      logic ring;
   } line_bits_t;
endpackage

// File: rtl/mdm_dtr_track.sv
module mdm_dtr_track #(
   parameter int NUM_LINES = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 init_i,
   input  logic                 wr_i,
   input  logic [NUM_LINES-1:0] dtr_in_i,
   input  logic                 hup_en_i,
   input  logic [NUM_LINES-1:0] up_i,
   output logic [NUM_LINES-1:0] dtr_eff_o,
   output logic [NUM_LINES-1:0] drop_o,
   output logic [NUM_LINES-1:0] hangup_o
);
   logic [NUM_LINES-1:0] dtr_q;
   logic [NUM_LINES-1:0] hup_q;
   logic                 drop_gate;

   assign drop_gate = wr_i & hup_en_i & ~init_i;
   assign dtr_eff_o = wr_i ? dtr_in_i : dtr_q;
   assign drop_o    = {NUM_LINES{drop_gate}} & dtr_q & ~dtr_in_i & up_i;
   assign hangup_o  = hup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dtr_q <= '0;
         hup_q <= '0;
      end else if (init_i) begin
         dtr_q <= '0;
         hup_q <= '0;
      end else begin
         if (wr_i) dtr_q <= dtr_in_i;
         hup_q <= drop_o;
      end
   end
endmodule

// File: rtl/mdm_line_cell.sv
module mdm_line_cell
   import mdm_status_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_i,
   input  logic       en_i,
   input  logic       wr_i,
   input  logic       dtr_new_i,
   input  logic       dtr_eff_i,
   input  logic       conn_i,
   input  logic       disc_i,
   input  logic       up_i,
   input  logic       drop_i,
   output line_bits_t st_o
);
   line_bits_t st_q;
   line_bits_t nxt;

   always_comb begin
      nxt = st_q;
      if (en_i) begin
         if (wr_i) begin
            if (dtr_new_i && st_q.ring) nxt.carrier = 1'b1;
            if (dtr_new_i)              nxt.ring    = 1'b0;
            if (drop_i)                 nxt.carrier = 1'b0;
         end
         if (conn_i) begin
            if (dtr_eff_i) nxt.carrier = 1'b1;
            else           nxt.ring    = 1'b1;
         end
         if (disc_i) begin
            nxt.ring    = 1'b0;
            nxt.carrier = 1'b0;
         end
         if (!up_i) nxt.carrier = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q <= '0;
      else if (init_i) st_q <= '0;
      else             st_q <= nxt;
   end

   assign st_o = st_q;
endmodule

// File: rtl/mdm_status_keeper.sv
module mdm_status_keeper
   import mdm_status_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   full_init_i,
   input  logic                   mdm_en_i,
   input  logic                   auto_hup_en_i,
   input  logic [NUM_LINES-1:0]   conn_i,
   input  logic [NUM_LINES-1:0]   disc_i,
   input  logic [NUM_LINES-1:0]   line_up_i,
   input  logic                   tcr_wr_i,
   input  logic [2*NUM_LINES-1:0] tcr_data_i,
   output logic [2*NUM_LINES-1:0] msr_o,
   output logic [NUM_LINES-1:0]   hangup_o
);
   localparam int WORD_W = 2 * NUM_LINES;

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("mdm_status_keeper: NUM_LINES out of range");
   end

   logic [NUM_LINES-1:0] dtr_new;
   logic [NUM_LINES-1:0] dtr_eff;
   logic [NUM_LINES-1:0] drop;
   logic [NUM_LINES-1:0] ring_v;
   logic [NUM_LINES-1:0] carrier_v;

   assign dtr_new = tcr_data_i[WORD_W-1:NUM_LINES];

   mdm_dtr_track #(.NUM_LINES(NUM_LINES)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_i    (full_init_i),
      .wr_i      (tcr_wr_i),
      .dtr_in_i  (dtr_new),
      .hup_en_i  (mdm_en_i & auto_hup_en_i),
      .up_i      (line_up_i),
      .dtr_eff_o (dtr_eff),
      .drop_o    (drop),
      .hangup_o  (hangup_o)
   );

   for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
      line_bits_t st;
      mdm_line_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .init_i    (full_init_i),
         .en_i      (mdm_en_i),
         .wr_i      (tcr_wr_i),
         .dtr_new_i (dtr_new[li]),
         .dtr_eff_i (dtr_eff[li]),
         .conn_i    (conn_i[li]),
         .disc_i    (disc_i[li]),
         .up_i      (line_up_i[li]),
         .drop_i    (drop[li]),
         .st_o      (st)
      );
      assign ring_v[li]    = st.ring;
      assign carrier_v[li] = st.carrier;
   end

   assign msr_o = {carrier_v, ring_v};
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk #(
   parameter int NUM_LINES = 8
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   full_init_i,
   input logic                   mdm_en_i,
   input logic                   auto_hup_en_i,
   input logic [NUM_LINES-1:0]   line_up_i,
   input logic                   tcr_wr_i,
   input logic [2*NUM_LINES-1:0] tcr_data_i,
   input logic [2*NUM_LINES-1:0] msr_o,
   input logic [NUM_LINES-1:0]   hangup_o
);
   p_init_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      full_init_i |=> (msr_o == '0 && hangup_o == '0));

   p_frozen_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mdm_en_i && !full_init_i) |=> $stable(msr_o));

   p_hangup_needs_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hangup_o != '0) |-> $past(tcr_wr_i && mdm_en_i && auto_hup_en_i && !full_init_i));

   p_hangup_drops_carrier_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hangup_o != '0) |-> ((msr_o[2*NUM_LINES-1:NUM_LINES] & hangup_o) == '0));

   p_down_no_carrier_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mdm_en_i |=> ((msr_o[2*NUM_LINES-1:NUM_LINES] & ~$past(line_up_i)) == '0));

   p_dtr_clears_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tcr_wr_i && mdm_en_i) |=>
         ((msr_o[NUM_LINES-1:0] & $past(tcr_data_i[2*NUM_LINES-1:NUM_LINES])) == '0));
endmodule

bind mdm_status_keeper mdm_status_chk #(.NUM_LINES(NUM_LINES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .full_init_i   (full_init_i),
   .mdm_en_i      (mdm_en_i),
   .auto_hup_en_i (auto_hup_en_i),
   .line_up_i     (line_up_i),
   .tcr_wr_i      (tcr_wr_i),
   .tcr_data_i    (tcr_data_i),
   .msr_o         (msr_o),
   .hangup_o      (hangup_o)
);

// File: tb/mdm_status_keeper_tb.sv
module mdm_status_keeper_tb;
   localparam int N = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           full_init_i = 1'b0;
   logic           mdm_en_i = 1'b0;
   logic           auto_hup_en_i = 1'b0;
   logic [N-1:0]   conn_i = '0;
   logic [N-1:0]   disc_i = '0;
   logic [N-1:0]   line_up_i = '0;
   logic           tcr_wr_i = 1'b0;
   logic [2*N-1:0] tcr_data_i = '0;
   logic [2*N-1:0] msr_o;
   logic [N-1:0]   hangup_o;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   logic [N-1:0] m_ring = '0, m_car = '0, m_dtr = '0, m_hup = '0;
   logic [31:0]  lfsr = 32'hACE1_1234;

   always #2 clk = ~clk;

   mdm_status_keeper #(.NUM_LINES(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .full_init_i(full_init_i), .mdm_en_i(mdm_en_i),
      .auto_hup_en_i(auto_hup_en_i), .conn_i(conn_i), .disc_i(disc_i),
      .line_up_i(line_up_i), .tcr_wr_i(tcr_wr_i), .tcr_data_i(tcr_data_i),
      .msr_o(msr_o), .hangup_o(hangup_o)
   );

   function automatic logic [31:0] nxt_rand(input logic [31:0] v);
      return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
   endfunction

   task automatic check(input string tag, input logic [2*N-1:0] act_msr,
                        input logic [N-1:0] act_hup);
      checks++;
      if (act_msr !== {m_car, m_ring}) begin
         errors++;
         $display("FAIL %s msr actual %h expected %h", tag, act_msr, {m_car, m_ring});
      end
      checks++;
      if (act_hup !== m_hup) begin
         errors++;
         $display("FAIL %s hangup actual %h expected %h", tag, act_hup, m_hup);
      end
   endtask

   // One clock step: drive at the falling edge, outputs settle after the rising
   // edge, compare at the next falling edge (R12).
   task automatic step(input string tag, input logic init, input logic [N-1:0] cn,
                       input logic [N-1:0] dc, input logic [N-1:0] up,
                       input logic wr, input logic [2*N-1:0] data);
      logic [N-1:0] nd, r, c, h;
      full_init_i = init; conn_i = cn; disc_i = dc; line_up_i = up;
      tcr_wr_i = wr; tcr_data_i = data;
      if (init) begin
         r = '0; c = '0; nd = '0; h = '0;
      end else begin
         nd = wr ? data[2*N-1:N] : m_dtr;
         h  = (wr && mdm_en_i && auto_hup_en_i) ? (m_dtr & ~nd & up) : '0;
         r = m_ring; c = m_car;
         if (mdm_en_i) begin
            if (wr) begin
               c = c | (nd & r);
               r = r & ~nd;
               c = c & ~h;
            end
            c = c | (cn & nd);
            r = r | (cn & ~nd);
            r = r & ~dc;
            c = c & ~dc & up;
         end
      end
      @(posedge clk);
      @(negedge clk);
      m_ring = r; m_car = c; m_dtr = nd; m_hup = h;
      check(tag, msr_o, hangup_o);
   endtask

   task automatic idle(input string tag, input logic [N-1:0] up);
      step(tag, 1'b0, '0, '0, up, 1'b0, '0);
   endtask

   initial begin
      int cyc = 0;
      while (!finished) begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", msr_o, hangup_o);
      rst_n = 1'b1;
      @(negedge clk);
      mdm_en_i = 1'b1;

      // R2 with R11: connect after write, low byte is the inverse of DTR
      for (int d = 0; d < 256; d++) begin
         step("R10 init", 1'b1, '0, '0, '1, 1'b0, '0);
         step("R11 dtr write", 1'b0, '0, '0, '1, 1'b1, {d[7:0], ~d[7:0]});
         step("R2 connect", 1'b0, '1, '0, '1, 1'b0, '0);
      end
      // R2: write and connect in the same cycle
      for (int d = 0; d < 256; d++) begin
         step("R10 init", 1'b1, '0, '0, '1, 1'b0, '0);
         step("R2 same-cycle", 1'b0, '1, '0, '1, 1'b1, {d[7:0], 8'h00});
      end
      // R3 R4: ringing lines turn to carrier on DTR
      for (int d = 0; d < 256; d++) begin
         step("R10 init", 1'b1, '0, '0, '1, 1'b0, '0);
         step("R2 ring", 1'b0, '1, '0, '1, 1'b0, '0);
         step("R3 R4 write", 1'b0, '0, '0, '1, 1'b1, {d[7:0], 8'h5A});
      end
      // R5 R6: hang-up on DTR drop, only for connected lines
      auto_hup_en_i = 1'b1;
      for (int d = 0; d < 256; d++) begin
         logic [7:0] u;
         u = 8'(d * 37 + 11);
         step("R10 init", 1'b1, '0, '0, '1, 1'b0, '0);
         step("R5 dtr high", 1'b0, '0, '0, '1, 1'b1, 16'hFF00);
         step("R2 connect", 1'b0, '1, '0, '1, 1'b0, '0);
         step("R6 lines down", 1'b0, '0, '0, u, 1'b0, '0);
         step("R5 drop", 1'b0, '0, '0, u, 1'b1, {d[7:0], 8'h00});
         idle("R5 pulse end", u);
      end
      // R7: disconnect pulses
      for (int d = 0; d < 256; d++) begin
         step("R10 init", 1'b1, '0, '0, '1, 1'b0, '0);
         step("R2 mixed", 1'b0, '1, '0, '1, 1'b1, 16'h0F00);
         step("R7 disconnect", 1'b0, '0, d[7:0], '1, 1'b0, '0);
      end
      // R8 R9: modem control off freezes the word and blocks hang-ups
      step("R10 init", 1'b1, '0, '0, '1, 1'b0, '0);
      step("R2 preload", 1'b0, '1, '0, '1, 1'b1, 16'h3300);
      mdm_en_i = 1'b0;
      for (int k = 0; k < 400; k++) begin
         lfsr = nxt_rand(lfsr);
         step("R8 R9 frozen", 1'b0, lfsr[7:0], lfsr[15:8], lfsr[23:16],
              lfsr[24], {lfsr[31:25], lfsr[3:0], lfsr[12:8]});
      end
      // R8: DTR is still recorded while off
      step("R8 record", 1'b0, '0, '0, '1, 1'b1, 16'hA500);
      mdm_en_i = 1'b1;
      step("R8 dtr kept", 1'b0, '1, '0, '1, 1'b0, '0);

      // Mixed traffic across all rules, init occasionally
      for (int k = 0; k < 3000; k++) begin
         lfsr = nxt_rand(lfsr);
         if (lfsr[5:0] == 6'd0) begin
            mdm_en_i = lfsr[6];
            auto_hup_en_i = lfsr[7];
         end
         lfsr = nxt_rand(lfsr);
         step("MIX R2 R3 R5 R6 R7 R10", (lfsr[31:27] == 5'd0),
              lfsr[7:0] & lfsr[15:8], lfsr[23:16] & lfsr[9:2],
              lfsr[15:8] | lfsr[26:19], lfsr[30], {lfsr[28:13], 16'h0} >> 16);
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule